// File: doc/BRIEF.md
# Management Bus Command Master

This block lets software run single read or write transactions against addressed slave units on an on-chip management bus. Those slaves usually sequence power and reset for peripherals. Software first loads the write-data register when the command is a write. It then writes one command word that carries a launch bit, a direction bit, an 8-bit slave address and a word offset.

From the launch until the end of the transaction, the block holds a request toward the slave. Software polls the command register. The launch bit reads back as 1 while the transaction runs and clears on its own when the transaction ends. Two sticky flags tell a slave error apart from an expired time limit. The time limit is programmable in clock cycles.

The host side is a plain register port: a write strobe, a byte address and write data, with read data decoded from the address in the same cycle. The slave side is a request held until the slave answers with an acknowledge or an error, or until the time limit ends the transaction.

Top module: `mbm_bus_master`

## Requirements
- R1: After reset the command register reads 0, the write-data and read-data registers read 0, the time-limit register reads TLIM_RST (default 1000), and sl_req is 0.
- R2: Host byte address 0x04 is write data, 0x08 is the time limit (low TW bits, default 16) and 0x0C is read data. The first two read back what was written. Writes to 0x0C have no effect. An address with bits 1:0 not 00 reads 0 and ignores writes.
- R3: A host write to address 0x00 with bit 31 set, while idle, launches a transaction. From the next cycle sl_req is 1, with sl_we equal to bit 20 (1 write, 0 read), sl_addr equal to bits 19:12, sl_off equal to bits OFF_W-1:0 and sl_wdata equal to the write-data register at launch. The command register then reads bits 31 and 28 as 1, with bits 20, 19:12 and 11:0 echoing the command.
- R4: While no acknowledge, error or timeout ends it, sl_req stays 1 and sl_we, sl_addr and sl_off stay unchanged.
- R5: A read that receives sl_ack=1 with sl_err=0 ends at that clock edge. The read-data register takes sl_rdata, and bits 31 and 28 clear.
- R6: A write that receives sl_ack=1 with sl_err=0 ends at that clock edge, and the read-data register keeps its value.
- R7: sl_err=1 during a request, with or without sl_ack, ends the transaction, sets command bit 29 and leaves the read-data register unchanged.
- R8: With time limit T and no response, the request lasts exactly T+1 cycles. The transaction then ends with command bit 30 set. T=0 gives one cycle.
- R9: A response in the last allowed cycle completes normally and takes priority over the timeout. A response while idle has no effect.
- R10: Bits 30 and 29 stay set until the next launching command write, which clears both.
- R11: A command write while a transaction runs is ignored, and so is a command write with bit 31 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| sl_req | output | 1 | Request to slave, held until the end |
| sl_we | output | 1 | 1 write, 0 read |
| sl_addr | output | 8 | Slave address |
| sl_off | output | OFF_W | Word offset inside the slave |
| sl_wdata | output | 32 | Data for a write |
| sl_ack | input | 1 | Slave acknowledge |
| sl_err | input | 1 | Slave error response |
| sl_rdata | input | 32 | Slave read data, valid with sl_ack |

## Verification
The slave's answer can land in the same cycle as the countdown reaching zero. The bench provokes this by programming limits of 2 and 0 and answering in exactly the last allowed cycle, then judges that the command ends without the timeout flag and that read data is captured. The bench also drives acknowledge and error together, and issues a command write in the final cycle of a running transaction. It checks that the error wins and that the late command is dropped.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    localparam int REG_W   = 32;
    localparam int START_B = 31;
    localparam int TOUT_B  = 30;
    localparam int SERR_B  = 29;
    localparam int BUSY_B  = 28;
    localparam int DIR_B   = 20;
    localparam int DST_LSB = 12;
    localparam int DST_W   = 8;
    localparam int OFF_MAX = 12;

    typedef enum logic [1:0] {
        IX_CTRL = 2'd0,
        IX_WDAT = 2'd1,
        IX_TLIM = 2'd2,
        IX_RDAT = 2'd3
    } reg_ix_e;

    typedef enum logic [1:0] {
        FIN_NONE,
        FIN_OK,
        FIN_SERR,
        FIN_TOUT
    } fin_e;

    typedef struct packed {
        logic busy;
        logic tout;
        logic serr;
    } stat_t;

    function automatic logic [REG_W-1:0] ctrl_word(stat_t s, logic wr,
                                                   logic [DST_W-1:0] dst,
                                                   logic [OFF_MAX-1:0] off);
        logic [REG_W-1:0] w;
        w = '0;
        w[START_B]          = s.busy;
        w[TOUT_B]           = s.tout;
        w[SERR_B]           = s.serr;
        w[BUSY_B]           = s.busy;
        w[DIR_B]            = wr;
        w[DST_LSB +: DST_W] = dst;
        w[OFF_MAX-1:0]      = off;
        return w;
    endfunction

endpackage

// File: rtl/mbm_seq.sv
module mbm_seq
    import mbm_pkg::*;
#(
    parameter int OFF_W = 12,
    parameter int TW    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                launch,
    input  logic                l_wr,
    input  logic [DST_W-1:0]    l_dst,
    input  logic [OFF_W-1:0]    l_off,
    input  logic [REG_W-1:0]    l_data,
    input  logic [TW-1:0]       l_tlim,
    input  logic                sl_ack,
    input  logic                sl_err,
    output stat_t               stat,
    output fin_e                fin,
    output logic                q_wr,
    output logic [DST_W-1:0]    q_dst,
    output logic [OFF_W-1:0]    q_off,
    output logic [REG_W-1:0]    q_data
);

    logic [TW-1:0] cnt;

    // outcome of the current cycle; a response outranks the countdown
    always_comb begin
        if (!stat.busy)      fin = FIN_NONE;
        else if (sl_err)     fin = FIN_SERR;
        else if (sl_ack)     fin = FIN_OK;
        else if (cnt == '0)  fin = FIN_TOUT;
        else                 fin = FIN_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat   <= '0;
            cnt    <= '0;
            q_wr   <= 1'b0;
            q_dst  <= '0;
            q_off  <= '0;
            q_data <= '0;
        end else if (stat.busy) begin
            case (fin)
                FIN_OK:   stat.busy <= 1'b0;
                FIN_SERR: begin
                    stat.busy <= 1'b0;
                    stat.serr <= 1'b1;
                end
                FIN_TOUT: begin
                    stat.busy <= 1'b0;
                    stat.tout <= 1'b1;
                end
                default:  cnt <= cnt - 1'b1;
            endcase
        end else if (launch) begin
            stat.busy <= 1'b1;
            stat.tout <= 1'b0;
            stat.serr <= 1'b0;
            cnt       <= l_tlim;
            q_wr      <= l_wr;
            q_dst     <= l_dst;
            q_off     <= l_off;
            q_data    <= l_data;
        end
    end

endmodule

// File: rtl/mbm_regs.sv
module mbm_regs
    import mbm_pkg::*;
#(
    parameter int TW       = 16,
    parameter int TLIM_RST = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_ix_e           ix,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              cap_en,
    input  logic [REG_W-1:0]  cap_data,
    input  logic [REG_W-1:0]  ctrl_in,
    output logic [REG_W-1:0]  wdat_q,
    output logic [TW-1:0]     tlim_q,
    output logic [REG_W-1:0]  rd_out
);

    logic [REG_W-1:0] rdat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wdat_q <= '0;
            tlim_q <= TW'(TLIM_RST);
            rdat_q <= '0;
        end else begin
            if (wr_en && ix == IX_WDAT) wdat_q <= wr_data;
            if (wr_en && ix == IX_TLIM) tlim_q <= wr_data[TW-1:0];
            if (cap_en)                 rdat_q <= cap_data;
        end
    end

    always_comb begin
        case (ix)
            IX_CTRL: rd_out = ctrl_in;
            IX_WDAT: rd_out = wdat_q;
            IX_TLIM: rd_out = REG_W'(tlim_q);
            default: rd_out = rdat_q;
        endcase
    end

endmodule

// File: rtl/mbm_bus_master.sv
module mbm_bus_master
    import mbm_pkg::*;
#(
    parameter int OFF_W    = 12,
    parameter int TW       = 16,
    parameter int TLIM_RST = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [3:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              sl_req,
    output logic              sl_we,
    output logic [7:0]        sl_addr,
    output logic [OFF_W-1:0]  sl_off,
    output logic [31:0]       sl_wdata,
    input  logic              sl_ack,
    input  logic              sl_err,
    input  logic [31:0]       sl_rdata
);

    stat_t              stat;
    fin_e               fin;
    reg_ix_e            ix;
    logic               aligned;
    logic               launch;
    logic               cap_en;
    logic [REG_W-1:0]   wdat_q;
    logic [TW-1:0]      tlim_q;
    logic [REG_W-1:0]   ctrl_q;
    logic [REG_W-1:0]   reg_rd;
    logic [REG_W-1:0]   rd_q;
    logic               busy_w;
    logic               tout_w;
    logic               serr_w;

    assign aligned = (host_addr[1:0] == 2'b00);
    assign ix      = reg_ix_e'(host_addr[3:2]);
    assign launch  = host_we && aligned && ix == IX_CTRL && host_wdata[START_B];
    assign cap_en  = (fin == FIN_OK) && !sl_we;

    mbm_seq #(.OFF_W(OFF_W), .TW(TW)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .l_wr   (host_wdata[DIR_B]),
        .l_dst  (host_wdata[DST_LSB +: DST_W]),
        .l_off  (host_wdata[OFF_W-1:0]),
        .l_data (wdat_q),
        .l_tlim (tlim_q),
        .sl_ack (sl_ack),
        .sl_err (sl_err),
        .stat   (stat),
        .fin    (fin),
        .q_wr   (sl_we),
        .q_dst  (sl_addr),
        .q_off  (sl_off),
        .q_data (sl_wdata)
    );

    assign ctrl_q = ctrl_word(stat, sl_we, sl_addr, OFF_MAX'(sl_off));

    mbm_regs #(.TW(TW), .TLIM_RST(TLIM_RST)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (host_we && aligned),
        .ix       (ix),
        .wr_data  (host_wdata),
        .cap_en   (cap_en),
        .cap_data (sl_rdata),
        .ctrl_in  (ctrl_q),
        .wdat_q   (wdat_q),
        .tlim_q   (tlim_q),
        .rd_out   (reg_rd)
    );

    assign host_rdata = aligned ? reg_rd : '0;
    assign sl_req     = stat.busy;
    assign busy_w     = stat.busy;
    assign tout_w     = stat.tout;
    assign serr_w     = stat.serr;
    assign rd_q       = u_regs.rdat_q;

endmodule

// File: rtl/mbm_checker.sv
module mbm_checker #(
    parameter int OFF_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              sl_req,
    input logic              sl_we,
    input logic [7:0]        sl_addr,
    input logic [OFF_W-1:0]  sl_off,
    input logic              sl_ack,
    input logic              sl_err,
    input logic [31:0]       sl_rdata,
    input logic              busy,
    input logic              tout,
    input logic              serr,
    input logic [31:0]       rd_q
);

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (sl_req && !sl_ack && !sl_err) |=> (sl_req || tout));

    assert_req_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (sl_req && $past(sl_req)) |->
            ($stable(sl_addr) && $stable(sl_off) && $stable(sl_we)));

    assert_read_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (sl_req && sl_ack && !sl_err && !sl_we) |=>
            (rd_q == $past(sl_rdata) && !busy));

    assert_rd_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (sl_req && (sl_we || sl_err)) |=> $stable(rd_q));

    assert_serr_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (sl_req && sl_err) |=> (serr && !busy && !sl_req));

    assert_tout_end_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(tout) |-> (!sl_req && !serr));

    assert_resp_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (sl_req && sl_ack && !sl_err) |=> !tout);

endmodule

bind mbm_bus_master mbm_checker #(.OFF_W(OFF_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sl_req   (sl_req),
    .sl_we    (sl_we),
    .sl_addr  (sl_addr),
    .sl_off   (sl_off),
    .sl_ack   (sl_ack),
    .sl_err   (sl_err),
    .sl_rdata (sl_rdata),
    .busy     (busy_w),
    .tout     (tout_w),
    .serr     (serr_w),
    .rd_q     (rd_q)
);

// File: tb/tb_mbm_bus_master.sv
`timescale 1ns/100ps
module tb_mbm_bus_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = 4'h0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        sl_req, sl_we;
    logic [7:0]  sl_addr;
    logic [11:0] sl_off;
    logic [31:0] sl_wdata;
    logic        sl_ack = 1'b0;
    logic        sl_err = 1'b0;
    logic [31:0] sl_rdata = '0;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    ended = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    mbm_bus_master dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sl_req(sl_req), .sl_we(sl_we), .sl_addr(sl_addr), .sl_off(sl_off),
        .sl_wdata(sl_wdata), .sl_ack(sl_ack), .sl_err(sl_err), .sl_rdata(sl_rdata)
    );

    // behavioural reference state
    bit          m_busy, m_tof, m_serr, m_we;
    int          m_cnt;
    bit [7:0]    m_dst;
    bit [11:0]   m_off;
    bit [31:0]   m_wd, m_cwd, m_rd;
    bit [15:0]   m_lim;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_tof = 0; m_serr = 0; m_we = 0; m_cnt = 0;
            m_dst = 0; m_off = 0; m_wd = 0; m_cwd = 0; m_rd = 0; m_lim = 16'd1000;
        end else begin
            if (host_we && host_addr == 4'h4) m_wd  = host_wdata;
            if (host_we && host_addr == 4'h8) m_lim = host_wdata[15:0];
            if (m_busy) begin
                if (sl_err) begin
                    m_busy = 0; m_serr = 1;
                end else if (sl_ack) begin
                    m_busy = 0;
                    if (!m_we) m_rd = sl_rdata;
                end else if (m_cnt == 0) begin
                    m_busy = 0; m_tof = 1;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end else if (host_we && host_addr == 4'h0 && host_wdata[31]) begin
                m_busy = 1; m_tof = 0; m_serr = 0;
                m_cnt = m_lim;
                m_we  = host_wdata[20];
                m_dst = host_wdata[19:12];
                m_off = host_wdata[11:0];
                m_cwd = m_wd;
            end
        end
    end

    function automatic bit [31:0] exp_rdata(bit [3:0] a);
        case (a)
            4'h0: return {m_busy, m_tof, m_serr, m_busy, 7'd0, m_we, m_dst, m_off};
            4'h4: return m_wd;
            4'h8: return {16'd0, m_lim};
            4'hC: return m_rd;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(string what, bit [31:0] act, bit [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    // compare every cycle, away from the clock edge
    always @(negedge clk) begin
        #1;
        if (!rst && !ended) begin
            check("host_rdata", host_rdata, exp_rdata(host_addr));
            check("sl_req", {31'd0, sl_req}, {31'd0, m_busy});
            if (m_busy) begin
                check("sl_we",    {31'd0, sl_we}, {31'd0, m_we});
                check("sl_addr",  {24'd0, sl_addr}, {24'd0, m_dst});
                check("sl_off",   {20'd0, sl_off}, {20'd0, m_off});
                check("sl_wdata", sl_wdata, m_cwd);
            end
        end
    end

    task automatic hwrite(bit [3:0] a, bit [31:0] d);
        @(negedge clk);
        host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 0; host_addr = 4'h0;
    endtask

    task automatic look(bit [3:0] a, int cyc);
        @(negedge clk);
        host_addr = a;
        repeat (cyc) @(negedge clk);
        host_addr = 4'h0;
    endtask

    // slave answer after wt cycles, for one cycle
    task automatic answer(int wt, bit a, bit e, bit [31:0] d);
        repeat (wt) @(negedge clk);
        sl_ack = a; sl_err = e; sl_rdata = d;
        @(negedge clk);
        sl_ack = 0; sl_err = 0; sl_rdata = 32'hDEAD_0000;
    endtask

    function automatic bit [31:0] cmd(bit st, bit wr, bit [7:0] dst, bit [11:0] off);
        return {st, 10'd0, wr, dst, off};
    endfunction

    task automatic finish_run();
        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        phase = "R1";
        look(4'h0, 1); look(4'h4, 1); look(4'h8, 1); look(4'hC, 1);

        phase = "R2";
        hwrite(4'h4, 32'hA5A5_0F0F);
        hwrite(4'h8, 32'h0000_0006);
        hwrite(4'hC, 32'h1234_5678);
        hwrite(4'h5, 32'hFFFF_FFFF);
        look(4'h4, 1); look(4'h8, 1); look(4'hC, 1); look(4'h5, 1);

        phase = "R3";
        hwrite(4'h0, cmd(1, 0, 8'h3C, 12'h123));
        phase = "R4";
        repeat (2) @(negedge clk);
        phase = "R5";
        answer(0, 1, 0, 32'hCAFE_F00D);
        look(4'hC, 2);

        phase = "R6";
        hwrite(4'h4, 32'h0BAD_BEEF);
        hwrite(4'h0, cmd(1, 1, 8'hE1, 12'hFFF));
        answer(3, 1, 0, 32'h1111_1111);
        look(4'hC, 1);

        phase = "R7";
        hwrite(4'h0, cmd(1, 0, 8'h07, 12'h010));
        answer(1, 0, 1, 32'h2222_2222);
        look(4'hC, 1);
        phase = "R10";
        repeat (3) @(negedge clk);
        phase = "R11";
        hwrite(4'h0, cmd(0, 1, 8'h55, 12'h055));
        phase = "R7";
        hwrite(4'h0, cmd(1, 0, 8'h08, 12'h020));
        answer(0, 1, 1, 32'h3333_3333);
        look(4'hC, 1);

        phase = "R8";
        hwrite(4'h8, 32'd4);
        hwrite(4'h0, cmd(1, 0, 8'h99, 12'h001));
        repeat (8) @(negedge clk);
        hwrite(4'h8, 32'd0);
        hwrite(4'h0, cmd(1, 1, 8'h9A, 12'h002));
        repeat (3) @(negedge clk);

        phase = "R10";
        hwrite(4'h0, cmd(1, 0, 8'h10, 12'h004));
        answer(0, 1, 0, 32'h4444_4444);

        phase = "R9";
        hwrite(4'h8, 32'd2);
        hwrite(4'h0, cmd(1, 0, 8'h20, 12'h008));
        answer(2, 1, 0, 32'h5555_5555);
        hwrite(4'h8, 32'd0);
        hwrite(4'h0, cmd(1, 0, 8'h21, 12'h009));
        answer(0, 1, 0, 32'h6666_6666);
        answer(2, 1, 0, 32'h7777_7777);
        look(4'hC, 1);

        phase = "R11";
        hwrite(4'h8, 32'd5);
        hwrite(4'h0, cmd(1, 0, 8'h30, 12'h0AA));
        hwrite(4'h0, cmd(1, 1, 8'h31, 12'h0BB));
        @(negedge clk);
        sl_ack = 1; sl_rdata = 32'h8888_8888;
        host_we = 1; host_addr = 4'h0; host_wdata = cmd(1, 1, 8'h32, 12'h0CC);
        @(negedge clk);
        sl_ack = 0; host_we = 0;
        repeat (3) @(negedge clk);
        look(4'hC, 1);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule